// File: doc/BRIEF.md
# I2C Event Status and Interrupt Vector Unit

This unit keeps the event status word, the interrupt enable mask and the DMA enable pair of a memory-mapped I2C master. The transfer engine raises single-cycle event pulses; each pulse latches a sticky status bit. Software reads the status word, clears bits on the newer revision by writing ones, or (older revision only) reads a vector select that names the lowest pending enabled event and clears it in the same access.

The unit drives one interrupt line and two DMA request lines. The interrupt line is high when an enabled event is pending. The receive and transmit requests follow the receive-ready and transmit-ready bits while the matching DMA enable is set. Turning on either DMA enable also drops the matching ready-interrupt enable. All three outputs are registered. A compile-time parameter selects the older or the newer revision.

Top module: `i2c_evt_unit`

## Requirements
- R1: After a synchronous active-low reset, the enable mask, the status word and the DMA pair read zero, and irq, rx_dma_req and tx_dma_req are low.
- R2: An event pulse on evt_set latches a status bit that stays set. Only positions 1 (no-ack), 2 (access ready), 3 (receive ready), 4 (transmit ready), 10 (transmit underflow), 11 (receive overrun) and 15 (single byte) are stored. Other pulse positions are dropped.
- R3: A read (rd_en with reg_sel) returns its data on rd_data on the cycle after the strobe. The selects are 0 mask, 1 status, 2 vector, 3 DMA and 4 test. Status reads show bus_busy, as sampled with the strobe, in bit 12, which is not stored. Test and unused selects read zero.
- R4: irq equals the OR of (status AND mask), taken from the state one cycle earlier.
- R5: On the older revision, a vector read returns one plus the index of the lowest set bit of (status AND mask), or zero when none is set, and clears that status bit. On the newer revision it returns zero and changes nothing.
- R6: A mask write keeps bits 4:0 on the older revision and bits 5:0 on the newer one.
- R7: On the newer revision, a status write clears each status bit where wr_data is one within 0x0027. On the older revision a status write has no effect.
- R8: A DMA write stores only bits 15 (receive DMA enable) and 7 (transmit DMA enable). A one in bit 15 clears mask bit 3, and a one in bit 7 clears mask bit 4.
- R9: rx_dma_req equals status bit 3 AND DMA bit 15, and tx_dma_req equals status bit 4 AND DMA bit 7, both from the state one cycle earlier.
- R10: On the newer revision, a test write with bit 11 set forces status bits 5:0 to one. On the older revision it has no effect.
- R11: When an event pulse and a clear (status write or vector read) hit the same bit in one cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid the cycle after rd_en |
| evt_set | input | 16 | Event set pulses from the transfer engine |
| bus_busy | input | 1 | Live bus-busy flag |
| irq | output | 1 | Interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The bench runs the older and the newer revision side by side on the same stimulus. It targets vector reads over an empty, a full and a partly masked status word. A wrong priority encoder there would return a higher index or clear the wrong bit. It also tests a DMA write while the ready enables are set: a design that skips the side effect would keep raising irq for events that DMA already serves. It drives pulses that collide with clears in the same cycle, which a clear-wins design would lose. It writes clear ones to the receive-ready and transmit-ready positions, which must survive.

// File: rtl/i2c_evt_pkg.sv
// Package: shared register selects and status bit positions for the
// I2C event unit. Assumes a 16-bit register data path.
package i2c_evt_pkg;
    localparam int DATA_W = 16;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_MASK = 3'd0,
        SEL_STAT = 3'd1,
        SEL_VEC  = 3'd2,
        SEL_DMA  = 3'd3,
        SEL_TEST = 3'd4
    } reg_sel_e;

    localparam int B_NOACK = 1;
    localparam int B_AREADY = 2;
    localparam int B_RXRDY = 3;
    localparam int B_TXRDY = 4;
    localparam int B_BUSY = 12;
    localparam int B_RXDMA = 15;
    localparam int B_TXDMA = 7;
    localparam int B_FORCE = 11;

    // positions an event pulse may latch
    localparam logic [DATA_W-1:0] EVT_BITS   = 16'h8C1E;
    // positions that the test force may set
    localparam logic [DATA_W-1:0] FORCE_BITS = 16'h003F;
    // positions a newer-revision status write may clear
    localparam logic [DATA_W-1:0] W1C_BITS   = 16'h0027;
endpackage

// File: rtl/i2c_evt_status.sv
// Sticky status word. Bits listed in KEEP_BITS are stored, all others read
// zero. Assumes set and clear vectors are already qualified by the caller;
// a set wins over a clear on the same bit.
module i2c_evt_status #(
    parameter int DW = 16,
    parameter logic [DW-1:0] KEEP_BITS = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_i,
    input  logic [DW-1:0] clr_i,
    output logic [DW-1:0] stat_o
);
    logic pv;

    // status storage: clear first, then set, restricted to stored positions
    always_ff @(posedge clk) begin
        if (!rst_n) stat_o <= '0;
        else        stat_o <= ((stat_o & ~clr_i) | set_i) & KEEP_BITS;
    end

    // marks that one clean cycle has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) pv <= 1'b0;
        else        pv <= 1'b1;
    end

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n || !pv)
        (stat_o & $past(set_i & KEEP_BITS)) == $past(set_i & KEEP_BITS));
    assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n || !pv)
        (stat_o & $past(clr_i & ~set_i)) == '0);
endmodule

// File: rtl/i2c_evt_vector.sv
// Lowest-pending priority encoder. Returns a one-hot of the lowest set bit
// of pend_i and its index plus one (zero when nothing is pending).
// Purely combinational; assumes CODE_W can hold DW.
module i2c_evt_vector #(
    parameter int DW = 16,
    localparam int CODE_W = $clog2(DW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     pend_i,
    output logic [DW-1:0]     hit_o,
    output logic [CODE_W-1:0] code_o
);
    logic [DW:0] seen;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < DW; i++) begin : g_chain
        assign hit_o[i]   = pend_i[i] & ~seen[i];
        assign seen[i+1]  = seen[i] | pend_i[i];
    end

    // index-plus-one of the selected bit
    always_comb begin
        code_o = '0;
        for (int i = 0; i < DW; i++)
            if (hit_o[i]) code_o = CODE_W'(i + 1);
    end

    assert_vec_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_o) && ((code_o == '0) == (pend_i == '0)));
endmodule

// File: rtl/i2c_evt_ctrl.sv
// Interrupt enable mask and DMA enable pair. A DMA write drops the
// matching ready-interrupt enable. Assumes write strobes are one-hot.
module i2c_evt_ctrl #(
    parameter int DW = 16,
    parameter bit NEWER = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_mask_i,
    input  logic          wr_dma_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] mask_o,
    output logic [DW-1:0] dma_o
);
    import i2c_evt_pkg::*;
    localparam logic [DW-1:0] MASK_KEEP = NEWER ? DW'(16'h003F) : DW'(16'h001F);
    localparam logic [DW-1:0] DMA_KEEP  = DW'((1 << B_RXDMA) | (1 << B_TXDMA));

    logic [DW-1:0] ie_drop;
    logic pv;

    assign ie_drop = (DW'(wdata_i[B_RXDMA]) << B_RXRDY) | (DW'(wdata_i[B_TXDMA]) << B_TXRDY);

    // mask register: direct write, or selective drop on DMA enable
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_o <= '0;
        else if (wr_mask_i) mask_o <= wdata_i & MASK_KEEP;
        else if (wr_dma_i)  mask_o <= mask_o & ~ie_drop;
    end

    // DMA enable register
    always_ff @(posedge clk) begin
        if (!rst_n)        dma_o <= '0;
        else if (wr_dma_i) dma_o <= wdata_i & DMA_KEEP;
    end

    // marks that one clean cycle has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) pv <= 1'b0;
        else        pv <= 1'b1;
    end

    assert_dma_drops_ie_R8: assert property (@(posedge clk) disable iff (!rst_n || !pv)
        ($past(wr_dma_i) && $past(wdata_i[B_RXDMA])) |-> !mask_o[B_RXRDY]);
    assert_mask_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o & ~MASK_KEEP) == '0);
endmodule

// File: rtl/i2c_evt_out.sv
// Registered interrupt and DMA request outputs. Each output reflects the
// status, mask and DMA state of the previous cycle.
module i2c_evt_out #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] stat_i,
    input  logic [DW-1:0] mask_i,
    input  logic [DW-1:0] dma_i,
    output logic          irq_o,
    output logic          rxq_o,
    output logic          txq_o
);
    import i2c_evt_pkg::*;
    logic pv;

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            rxq_o <= 1'b0;
            txq_o <= 1'b0;
        end else begin
            irq_o <= |(stat_i & mask_i);
            rxq_o <= stat_i[B_RXRDY] & dma_i[B_RXDMA];
            txq_o <= stat_i[B_TXRDY] & dma_i[B_TXDMA];
        end
    end

    // marks that one clean cycle has passed since reset
    always_ff @(posedge clk) begin
        if (!rst_n) pv <= 1'b0;
        else        pv <= 1'b1;
    end

    assert_irq_lag_R4: assert property (@(posedge clk) disable iff (!rst_n || !pv)
        irq_o == $past(|(stat_i & mask_i)));
    assert_txreq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n || !pv)
        txq_o |-> $past(dma_i[B_TXDMA]));
endmodule

// File: rtl/i2c_evt_unit.sv
// Top of the I2C event unit: register decode, status qualification, read
// mux and output stage. NEWER selects the newer revision (write-one-clear
// status, 6-bit mask, test force) versus the older one (vector read).
// Assumes at most one of wr_en and rd_en per cycle.
module i2c_evt_unit #(
    parameter bit NEWER = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [i2c_evt_pkg::SEL_W-1:0] reg_sel,
    input  logic [i2c_evt_pkg::DATA_W-1:0] wr_data,
    output logic [i2c_evt_pkg::DATA_W-1:0] rd_data,
    input  logic [i2c_evt_pkg::DATA_W-1:0] evt_set,
    input  logic                          bus_busy,
    output logic                          irq,
    output logic                          rx_dma_req,
    output logic                          tx_dma_req
);
    import i2c_evt_pkg::*;
    localparam int DW = DATA_W;
    localparam int CODE_W = $clog2(DW + 1);

    logic [DW-1:0] stat, mask, dma, set_vec, clr_vec, hit;
    logic [CODE_W-1:0] code;
    logic wr_mask, wr_stat, wr_dma, wr_test, rd_vec;

    assign wr_mask = wr_en && reg_sel == SEL_MASK;
    assign wr_stat = wr_en && reg_sel == SEL_STAT && NEWER;
    assign wr_dma  = wr_en && reg_sel == SEL_DMA;
    assign wr_test = wr_en && reg_sel == SEL_TEST && NEWER;
    assign rd_vec  = rd_en && reg_sel == SEL_VEC && !NEWER;

    // set and clear vectors for the status word
    always_comb begin
        set_vec = evt_set & EVT_BITS;
        if (wr_test && wr_data[B_FORCE]) set_vec = set_vec | FORCE_BITS;
        clr_vec = '0;
        if (wr_stat) clr_vec = wr_data & W1C_BITS;
        if (rd_vec)  clr_vec = clr_vec | hit;
    end

    i2c_evt_status #(.DW(DW), .KEEP_BITS(EVT_BITS | FORCE_BITS)) u_status (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .stat_o(stat)
    );

    i2c_evt_vector #(.DW(DW)) u_vector (
        .clk(clk), .rst_n(rst_n), .pend_i(stat & mask), .hit_o(hit), .code_o(code)
    );

    i2c_evt_ctrl #(.DW(DW), .NEWER(NEWER)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_mask_i(wr_mask), .wr_dma_i(wr_dma),
        .wdata_i(wr_data), .mask_o(mask), .dma_o(dma)
    );

    i2c_evt_out #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .stat_i(stat), .mask_i(mask), .dma_i(dma),
        .irq_o(irq), .rxq_o(rx_dma_req), .txq_o(tx_dma_req)
    );

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) begin
            case (reg_sel)
                SEL_MASK: rd_data <= mask;
                SEL_STAT: rd_data <= stat | (DW'(bus_busy) << B_BUSY);
                SEL_VEC:  rd_data <= NEWER ? '0 : DW'(code);
                SEL_DMA:  rd_data <= dma;
                default:  rd_data <= '0;
            endcase
        end
    end

    assert_busy_not_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[B_BUSY]);
    assert_old_stat_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!NEWER && wr_en && reg_sel == SEL_STAT) |-> (clr_vec == '0));
endmodule

// File: tb/tb_i2c_evt_unit.sv
// Runs both revisions on shared stimulus against a bench model.
module tb_i2c_evt_unit;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, bus_busy = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [15:0] wr_data = '0, evt_set = '0;
    logic [15:0] rdo [2];
    logic irqo [2], rxo [2], txo [2];
    int n_chk = 0, n_fail = 0;

    logic [15:0] m_mask [2], m_stat [2], m_dma [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_evt_unit #(.NEWER(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rdo[0]), .evt_set(evt_set), .bus_busy(bus_busy),
        .irq(irqo[0]), .rx_dma_req(rxo[0]), .tx_dma_req(txo[0]));
    i2c_evt_unit #(.NEWER(1'b1)) dut_nr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rdo[1]), .evt_set(evt_set), .bus_busy(bus_busy),
        .irq(irqo[1]), .rx_dma_req(rxo[1]), .tx_dma_req(txo[1]));

    task automatic chk(input string tag, input int r, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s rev%0d actual=%h expected=%h", tag, r, act, exp);
        end
    endtask

    function automatic logic [15:0] lowest(input logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return 16'(1) << i;
        return '0;
    endfunction

    function automatic logic [15:0] low_code(input logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return 16'(i + 1);
        return '0;
    endfunction

    // one clock with the currently driven inputs; checks every output
    task automatic step(input string tag);
        logic [15:0] nm [2], ns [2], nd [2], er [2], setv, clr;
        logic ei [2], erx [2], etx [2];
        string t;
        for (int r = 0; r < 2; r++) begin
            ei[r]  = |(m_stat[r] & m_mask[r]);
            erx[r] = m_stat[r][3] & m_dma[r][15];
            etx[r] = m_stat[r][4] & m_dma[r][7];
            case (reg_sel)
                3'd0: er[r] = m_mask[r];
                3'd1: er[r] = m_stat[r] | (16'(bus_busy) << 12);
                3'd2: er[r] = r ? 16'h0 : low_code(m_stat[r] & m_mask[r]);
                3'd3: er[r] = m_dma[r];
                default: er[r] = '0;
            endcase
            setv = evt_set & 16'h8C1E;
            clr = '0;
            if (r == 1 && wr_en && reg_sel == 3'd4 && wr_data[11]) setv |= 16'h003F;
            if (r == 1 && wr_en && reg_sel == 3'd1) clr = wr_data & 16'h0027;
            if (r == 0 && rd_en && reg_sel == 3'd2) clr = lowest(m_stat[r] & m_mask[r]);
            ns[r] = (m_stat[r] & ~clr) | setv;
            nm[r] = m_mask[r];
            nd[r] = m_dma[r];
            if (wr_en && reg_sel == 3'd0) nm[r] = wr_data & (r ? 16'h003F : 16'h001F);
            if (wr_en && reg_sel == 3'd3) begin
                nd[r] = wr_data & 16'h8080;
                if (wr_data[15]) nm[r][3] = 1'b0;
                if (wr_data[7])  nm[r][4] = 1'b0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int r = 0; r < 2; r++) begin
            chk("R4", r, 16'(irqo[r]), 16'(ei[r]));
            chk("R9", r, 16'(rxo[r]), 16'(erx[r]));
            chk("R9", r, 16'(txo[r]), 16'(etx[r]));
            if (rd_en) begin
                if (tag != "") t = tag;
                else case (reg_sel)
                    3'd0: t = "R6";
                    3'd1: t = "R7";
                    3'd2: t = "R5";
                    3'd3: t = "R8";
                    default: t = "R3";
                endcase
                chk(t, r, rdo[r], er[r]);
            end
            m_mask[r] = nm[r]; m_stat[r] = ns[r]; m_dma[r] = nd[r];
        end
        wr_en = 1'b0; rd_en = 1'b0; evt_set = '0;
    endtask

    task automatic do_wr(input logic [2:0] s, input logic [15:0] d, input string tag);
        wr_en = 1'b1; reg_sel = s; wr_data = d; step(tag);
    endtask

    task automatic do_rd(input logic [2:0] s, input string tag);
        rd_en = 1'b1; reg_sel = s; step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int r = 0; r < 2; r++) begin
            m_mask[r] = '0; m_stat[r] = '0; m_dma[r] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state through reads and idle outputs
        do_rd(3'd0, "R1");
        do_rd(3'd1, "R1");
        do_rd(3'd3, "R1");
        // R5: empty vector returns zero
        do_rd(3'd2, "R5");
        // R2: every pulse position, only the stored ones stick
        evt_set = 16'hFFFF; step("R2");
        bus_busy = 1'b1;
        do_rd(3'd1, "R2");
        bus_busy = 1'b0;
        do_rd(3'd1, "R3");
        do_rd(3'd4, "R3");
        // R6: mask width per revision
        do_wr(3'd0, 16'hFFFF, "");
        do_rd(3'd0, "R6");
        // R5: walk the vector down on the older revision
        for (int k = 0; k < 7; k++) do_rd(3'd2, "R5");
        // R7: write-one-clear, ready bits survive
        evt_set = 16'h001E; step("R2");
        do_wr(3'd1, 16'hFFFF, "");
        do_rd(3'd1, "R7");
        // R8: DMA enable drops ready enables
        do_wr(3'd0, 16'h003F, "");
        do_wr(3'd3, 16'hFFFF, "");
        do_rd(3'd0, "R8");
        do_rd(3'd3, "R8");
        // R9: requests follow ready bits
        evt_set = 16'h0018; step("R9");
        step("R9");
        // R10: test force
        do_wr(3'd1, 16'h0027, "");
        do_wr(3'd4, 16'h0800, "");
        do_rd(3'd1, "R10");
        // R11: pulse collides with a clear on the same bit
        do_wr(3'd0, 16'h0004, "");
        wr_en = 1'b1; reg_sel = 3'd1; wr_data = 16'h0004; evt_set = 16'h0004; step("R11");
        do_rd(3'd1, "R11");
        rd_en = 1'b1; reg_sel = 3'd2; evt_set = 16'h0004; step("R11");
        do_rd(3'd1, "R11");
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            int op;
            op = int'($urandom % 7);
            bus_busy = 1'($urandom);
            if ($urandom % 3 == 0) evt_set = 16'($urandom);
            case (op)
                0: begin wr_en = 1'b1; reg_sel = 3'd0; wr_data = 16'($urandom); end
                1: begin wr_en = 1'b1; reg_sel = 3'd1; wr_data = 16'($urandom); end
                2: begin wr_en = 1'b1; reg_sel = 3'd3;
                         wr_data = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0000; end
                3: begin wr_en = 1'b1; reg_sel = 3'd4; wr_data = 16'($urandom); end
                4, 5: begin rd_en = 1'b1; reg_sel = 3'($urandom % 6); end
                default: ;
            endcase
            step("");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule